// File: doc/BRIEF.md
# Divided-Clock Set/Reset Latch Peripheral

This peripheral holds a single bit of state in a set/reset latch, under a small register port. Software writes one 8-bit control word. The word turns the latch on, picks a power-of-two division of the peripheral clock, chooses which of the true and inverted outputs reach the shared pin, and can fire one-shot set and reset pulses. The pulse bits clear themselves after one cycle. They always read back as zero.

The divider makes a one-cycle tick once every N peripheral cycles, where N is 4 to 512. A source-select input routes that tick to the set side of the latch, to the reset side, or to neither, so the latch can be armed or cleared on a fixed period. When set and reset arrive together, reset wins. While the latch is off, its state is held at 0 and the divider counter is held at zero.

Top module: `pulse_latch_unit`

## Requirements
- R1: After reset, all control bits are 0, `rdData` reads 0x00, and both `pinEnable` and `pinData` are 0.
- R2: The control word has these fields: bit 7 is the enable, bits 6:4 are the divider select, bit 3 is the true-output enable, bit 2 is the inverted-output enable, bit 1 is the pulse-set bit and bit 0 is the pulse-reset bit. `rdData[7:2]` returns the last written bits 7:2.
- R3: While the enable bit is 0, the latch state is forced to 0 from the next clock edge, and pulse-set writes have no effect on it.
- R4: With the enable at 1, writing 1 to bit 1 sets the latch. The state is visible at the pins after the second rising edge that follows the write cycle. `rdData[1:0]` always reads 00, including the cycle right after the write.
- R5: With the enable at 1, writing 1 to bit 0 clears the latch, with the same timing as R4.
- R6: When a set strobe and a reset strobe reach the latch in the same cycle, the latch becomes 0.
- R7: Divider select value s gives a period N = 2^(s+2). After the edge that enables the latch, the first tick takes effect on the latch at edge N. A later tick follows every N cycles. `srcSel` 01 routes the tick to set, 10 routes it to reset, and 00 or 11 route it nowhere.
- R8: The divider counter restarts from zero while the enable is 0. After re-enabling, a full N cycles pass before the first tick.
- R9: `pinEnable` is the OR of the two output enables. `pinData` is the latch state when the true-output enable is 1, whatever the inverted-output enable holds. It is the inverted state when only the inverted-output enable is 1, and it is 0 when neither is set.
- R10: Each pulse bit acts for exactly one cycle. A reset pulse followed at once by a set pulse leaves the latch at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 8 | Control word to write |
| srcSel | input | 2 | Divided tick routing: 01 set, 10 reset, 00/11 none |
| rdData | output | 8 | Control word readback, pulse bits read 0 |
| pinData | output | 1 | Value driven onto the shared pin |
| pinEnable | output | 1 | Pin drive enable |

## Verification
The bench builds the block with its default parameters: a 3-bit divider select and a minimum shift of 2. This makes every ratio from 4 to 512 reachable within a few hundred cycles. The bench times the first tick for ratios 4, 8 and 512. It checks the reset-side routing at ratio 4 and confirms that both no-route codes stay silent. It also checks the restart of the counter after a disable in the middle of a period.

// File: rtl/pulse_latch_pkg.sv
package pulse_latch_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_SET  = 2'b01,
    SRC_RST  = 2'b10,
    SRC_OFF  = 2'b11
  } tick_src_e;

  typedef struct packed {
    logic enable;
    logic setStb;
    logic rstStb;
    logic qEn;
    logic nqEn;
  } latch_ctl_t;

endpackage

// File: rtl/pulse_latch_div.sv
module pulse_latch_div #(
  parameter int SEL_W     = 3,
  parameter int MIN_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CNT_W = MIN_SHIFT + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [CNT_W:0]   ratio;
  logic [CNT_W:0]   ratioM1;
  int               shiftIdx;

  always_comb begin
    shiftIdx = MIN_SHIFT + int'(sel);
    ratio = '0;
    ratio[shiftIdx] = 1'b1;
    ratioM1 = ratio - 1'b1;
    limit = ratioM1[CNT_W-1:0];
  end

  assign tick = enable && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8: counter held at zero while disabled
  p_div_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (cnt == '0));

  // R7: ratio is at least 4, so ticks never come back to back
  p_tick_gap_r7: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/pulse_latch_ctrl.sv
module pulse_latch_ctrl
  import pulse_latch_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int MIN_SHIFT = 2,
  localparam int REG_W    = SEL_W + 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic [1:0]       srcSel,
  output logic [REG_W-1:0] rdData,
  output latch_ctl_t       ctl
);
  localparam int EN_BIT  = REG_W - 1;
  localparam int SEL_LO  = 4;
  localparam int QEN_BIT = 3;
  localparam int NQ_BIT  = 2;
  localparam int SET_BIT = 1;
  localparam int RST_BIT = 0;

  logic             enReg;
  logic [SEL_W-1:0] selReg;
  logic             qEnReg;
  logic             nqEnReg;
  logic             pulseSet;
  logic             pulseRst;
  logic             tick;
  tick_src_e        route;

  always_ff @(posedge clk) begin
    if (rst) begin
      enReg    <= 1'b0;
      selReg   <= '0;
      qEnReg   <= 1'b0;
      nqEnReg  <= 1'b0;
      pulseSet <= 1'b0;
      pulseRst <= 1'b0;
    end else begin
      pulseSet <= wrEn && wrData[SET_BIT];
      pulseRst <= wrEn && wrData[RST_BIT];
      if (wrEn) begin
        enReg   <= wrData[EN_BIT];
        selReg  <= wrData[SEL_LO +: SEL_W];
        qEnReg  <= wrData[QEN_BIT];
        nqEnReg <= wrData[NQ_BIT];
      end
    end
  end

  pulse_latch_div #(
    .SEL_W    (SEL_W),
    .MIN_SHIFT(MIN_SHIFT)
  ) i_div (
    .clk   (clk),
    .rst   (rst),
    .enable(enReg),
    .sel   (selReg),
    .tick  (tick)
  );

  assign route = tick_src_e'(srcSel);

  always_comb begin
    ctl.enable = enReg;
    ctl.qEn    = qEnReg;
    ctl.nqEn   = nqEnReg;
    ctl.setStb = pulseSet || (tick && route == SRC_SET);
    ctl.rstStb = pulseRst || (tick && route == SRC_RST);
  end

  assign rdData = {enReg, selReg, qEnReg, nqEnReg, 2'b00};

  // R10: pulse bits live for one cycle only
  p_selfclear_r10: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> (!pulseSet && !pulseRst));

  // R7: no tick reaches set when routing is not the set code
  p_route_set_r7: assert property (@(posedge clk) disable iff (rst)
    (route != SRC_SET && !pulseSet) |-> !ctl.setStb);

endmodule

// File: rtl/pulse_latch_dp.sv
module pulse_latch_dp
  import pulse_latch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  latch_ctl_t ctl,
  output logic       pinData,
  output logic       pinEnable
);
  logic qState;

  always_ff @(posedge clk) begin
    if (rst || !ctl.enable) begin
      qState <= 1'b0;
    end else if (ctl.rstStb) begin
      qState <= 1'b0;
    end else if (ctl.setStb) begin
      qState <= 1'b1;
    end
  end

  always_comb begin
    pinEnable = ctl.qEn || ctl.nqEn;
    if (ctl.qEn) begin
      pinData = qState;
    end else if (ctl.nqEn) begin
      pinData = !qState;
    end else begin
      pinData = 1'b0;
    end
  end

  // R3: disabled latch holds no state
  p_disabled_clear_r3: assert property (@(posedge clk) disable iff (rst)
    !ctl.enable |=> !qState);

  // R6: reset strobe beats set strobe
  p_reset_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl.enable && ctl.rstStb) |=> !qState);

  // R4: set strobe alone sets the latch
  p_set_takes_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl.enable && ctl.setStb && !ctl.rstStb) |=> qState);

  // R9: no drive without an output enable
  p_pin_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !pinEnable |-> !pinData);

endmodule

// File: rtl/pulse_latch_unit.sv
module pulse_latch_unit
  import pulse_latch_pkg::*;
#(
  parameter int SEL_W     = 3,
  parameter int MIN_SHIFT = 2,
  localparam int REG_W    = SEL_W + 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic [1:0]       srcSel,
  output logic [REG_W-1:0] rdData,
  output logic             pinData,
  output logic             pinEnable
);
  latch_ctl_t ctl;

  pulse_latch_ctrl #(
    .SEL_W    (SEL_W),
    .MIN_SHIFT(MIN_SHIFT)
  ) i_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wrEn  (wrEn),
    .wrData(wrData),
    .srcSel(srcSel),
    .rdData(rdData),
    .ctl   (ctl)
  );

  pulse_latch_dp i_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .pinData  (pinData),
    .pinEnable(pinEnable)
  );

endmodule

// File: tb/test_pulse_latch_unit.sv
`timescale 1ns/1ps
module test_pulse_latch_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [1:0] srcSel = 2'b00;
  logic [7:0] rdData;
  logic       pinData;
  logic       pinEnable;

  int errors = 0;
  int checks = 0;

  always #2 clk = !clk;

  pulse_latch_unit i_pulse_latch_unit (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .srcSel(srcSel), .rdData(rdData), .pinData(pinData), .pinEnable(pinEnable)
  );

  typedef struct packed {
    logic [7:0] wr;
    logic       expEn;
    logic       expData;
    logic [7:0] expRd;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t TBL [NVEC] = '{
    '{8'h88, 1'b1, 1'b0, 8'h88},  // R2 R9: enabled, true output, state 0
    '{8'h8A, 1'b1, 1'b1, 8'h88},  // R4: pulse set
    '{8'h84, 1'b1, 1'b0, 8'h84},  // R9: inverted output only
    '{8'h8D, 1'b1, 1'b0, 8'h8C},  // R5 R9: reset pulse, both enables
    '{8'h8F, 1'b1, 1'b0, 8'h8C},  // R6: both pulses, reset wins
    '{8'h8E, 1'b1, 1'b1, 8'h8C},  // R4 R9: set, true output wins
    '{8'h80, 1'b0, 1'b0, 8'h80},  // R9: no output enable
    '{8'h88, 1'b1, 1'b1, 8'h88},  // R9: state kept
    '{8'h08, 1'b1, 1'b0, 8'h08},  // R3: disable clears state
    '{8'h0A, 1'b1, 1'b0, 8'h08},  // R3: pulse set ignored while off
    '{8'h04, 1'b1, 1'b1, 8'h04},  // R3 R9: inverted view of 0
    '{8'h8C, 1'b1, 1'b0, 8'h8C}   // R3: re-enable starts at 0
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
    wrData = 8'h00;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic divSetCheck(input logic [2:0] sel, input int n);
    srcSel = 2'b01;
    wr(8'h08);
    wr({1'b1, sel, 4'b1000});
    edges(n - 1);
    chk($sformatf("R7 set tick sel%0d before", sel), {15'd0, pinData}, 16'd0);
    edges(1);
    chk($sformatf("R7 set tick sel%0d at N", sel), {15'd0, pinData}, 16'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    edges(3);
    rst = 1'b0;
    edges(1);
    chk("R1 rdData after reset", {8'd0, rdData}, 16'h0000);
    chk("R1 pins after reset", {14'd0, pinEnable, pinData}, 16'd0);

    for (int i = 0; i < NVEC; i++) begin
      wr(TBL[i].wr);
      edges(1);
      chk($sformatf("R2/R9 table %0d pins", i), {14'd0, pinEnable, pinData},
          {14'd0, TBL[i].expEn, TBL[i].expData});
      chk($sformatf("R2 table %0d readback", i), {8'd0, rdData}, {8'd0, TBL[i].expRd});
    end

    // R4: pulse bits read 0 the cycle right after the write
    wr(8'h8B);
    chk("R4 pulse bits read zero", {14'd0, rdData[1:0]}, 16'd0);
    edges(1);

    // R10: reset pulse followed at once by set pulse
    wr(8'h89);
    wr(8'h8A);
    edges(1);
    chk("R10 back-to-back pulses", {15'd0, pinData}, 16'd1);

    // R7: first-tick timing for three ratios
    divSetCheck(3'd0, 4);
    divSetCheck(3'd1, 8);
    divSetCheck(3'd7, 512);

    // R7: reset routing at ratio 4
    srcSel = 2'b10;
    wr(8'h08);
    wr(8'h8A);
    edges(3);
    chk("R7 reset tick before", {15'd0, pinData}, 16'd1);
    edges(1);
    chk("R7 reset tick at N", {15'd0, pinData}, 16'd0);

    // R7: codes 00 and 11 route nowhere
    for (int c = 0; c < 4; c += 3) begin
      srcSel = 2'(c);
      wr(8'h08);
      wr(8'h88);
      edges(20);
      chk($sformatf("R7 no route code %0d", c), {15'd0, pinData}, 16'd0);
    end

    // R8: disable mid-period restarts the count
    srcSel = 2'b01;
    wr(8'h08);
    wr(8'h98);
    edges(5);
    wr(8'h08);
    edges(3);
    wr(8'h98);
    edges(7);
    chk("R8 restart before N", {15'd0, pinData}, 16'd0);
    edges(1);
    chk("R8 restart at N", {15'd0, pinData}, 16'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule